// File: doc/BRIEF.md
# Overcurrent Fault Flag with Clean-Cycle Hold

This block watches the overcurrent indications of a push-pull output stage, one for the high-side switch and one for the low-side switch. It raises a shared fault signal as soon as either indication trips. The fault is not released on a timer. It drops only after a fixed number of consecutive switching periods of the stage's control input have passed with no overcurrent on either side.

Two qualifying inputs, an enable and an active-low arm input, release the fault at once. The output gate reacts to them in the same cycle, and the held fault state is discarded once the synchronised copy of either input shows it low. While either input is low, the block ignores new overcurrent indications.

The fault leaves the block as a pull-low enable, so several blocks can share one wired-OR line, together with a resolved level that models the line with its pull-up. All asynchronous inputs pass through a multi-stage synchroniser before the hold logic uses them.

Top module: `ofh_fault_flag`

## Requirements
- R1: After `rst_n` is released with no overcurrent, `flt_pull_low` is 0 and `flt_line_n` is 1.
- R2: An overcurrent on `oc_hi` sampled at a clock edge while enabled and armed sets the fault. `flt_pull_low` goes to 1 after SYNC_STAGES+1 rising clock edges.
- R3: `oc_lo` sets the fault exactly as `oc_hi` does.
- R4: `flt_line_n` is 0 when `flt_pull_low` is 1 and 1 otherwise. The block never drives the line high.
- R5: A set fault is released only when HOLD_CYCLES rising edges of the synchronised `sw_ref` (default 4) have been seen with no overcurrent. The release shows on the clock after the last of those edges has been registered.
- R6: An overcurrent seen at any clock while the fault is held restarts the clean-edge count from zero.
- R7: `en` low forces `flt_pull_low` to 0 in the same cycle, and the held fault is discarded.
- R8: `arm_n` low forces `flt_pull_low` to 0 in the same cycle, and the held fault is discarded.
- R9: While the synchronised `en` or `arm_n` is low, overcurrent indications do not set the fault. The output stays released after both return high if no overcurrent follows.
- R10: Clock cycles without a rising edge of `sw_ref` never release the fault, however many of them pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_ref | input | 1 | Switching control input, used as the cycle reference |
| oc_hi | input | 1 | High-side overcurrent indication, active high |
| oc_lo | input | 1 | Low-side overcurrent indication, active high |
| en | input | 1 | Enable; low releases and blocks the fault |
| arm_n | input | 1 | Functional reset, active low; low releases and blocks the fault |
| flt_pull_low | output | 1 | Pull-low enable for the shared fault line |
| flt_line_n | output | 1 | Resolved fault line level, 0 while the fault is active |

## Verification
On every clock, the assertions check several invariants:
- a synchronised overcurrent sets the fault on the next edge;
- a synchronised block clears it;
- the held fault survives every cycle that lacks a reference rising edge;
- the clean-edge count stays below its limit and returns to zero after an overcurrent;
- a low `en` or `arm_n` removes the pull at once.

Only the bench scenarios can show the exact number of reference edges needed for release, and that an overcurrent in the middle of a hold restarts the full count. They also show that indications applied while the block is disabled leave no trace after it is enabled again.

// File: rtl/ofh_pkg.sv
package ofh_pkg;
  // Depth of the input synchroniser and the default clean-edge hold count.
  parameter int unsigned SYNC_STAGES_DEF = 2;
  parameter int unsigned HOLD_CYCLES_DEF = 4;

  // Indices of the synchronised input vector.
  typedef enum int unsigned {
    IX_REF = 0,
    IX_HI  = 1,
    IX_LO  = 2,
    IX_EN  = 3,
    IX_ARM = 4
  } in_idx_e;

  localparam int unsigned N_INPUTS = 5;
endpackage

// File: rtl/ofh_sync.sv
module ofh_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ofh_edge.sv
module ofh_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ofh_hold.sv
module ofh_hold #(
  parameter int unsigned HOLD_CYCLES = 4,
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blocked,
  input  logic          oc_any,
  input  logic          ref_rise,
  output logic          fault,
  output logic [CW-1:0] clean_cnt
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          fault_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    fault_d = fault;
    cnt_d   = clean_cnt;
    if (blocked) begin
      fault_d = 1'b0;
      cnt_d   = '0;
    end else if (oc_any) begin
      fault_d = 1'b1;
      cnt_d   = '0;
    end else if (fault && ref_rise) begin
      if (clean_cnt == LAST) begin
        fault_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = clean_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault     <= 1'b0;
      clean_cnt <= '0;
    end else begin
      fault     <= fault_d;
      clean_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/ofh_fault_flag.sv
module ofh_fault_flag
  import ofh_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned HOLD_CYCLES = HOLD_CYCLES_DEF,
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_ref,
  input  logic oc_hi,
  input  logic oc_lo,
  input  logic en,
  input  logic arm_n,
  output logic flt_pull_low,
  output logic flt_line_n
);
  logic [N_INPUTS-1:0] raw_in;
  logic [N_INPUTS-1:0] sync_in;
  logic                ref_rise;
  logic                oc_s;
  logic                blocked_s;
  logic                fault_q;
  logic [CW-1:0]       hold_cnt;

  always_comb begin
    raw_in         = '0;
    raw_in[IX_REF] = sw_ref;
    raw_in[IX_HI]  = oc_hi;
    raw_in[IX_LO]  = oc_lo;
    raw_in[IX_EN]  = en;
    raw_in[IX_ARM] = arm_n;
  end

  ofh_sync #(.WIDTH(N_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  ofh_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sync_in[IX_REF]),
    .rise  (ref_rise)
  );

  assign oc_s      = sync_in[IX_HI] | sync_in[IX_LO];
  assign blocked_s = ~sync_in[IX_EN] | ~sync_in[IX_ARM];

  ofh_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .blocked   (blocked_s),
    .oc_any    (oc_s),
    .ref_rise  (ref_rise),
    .fault     (fault_q),
    .clean_cnt (hold_cnt)
  );

  // The raw qualifiers gate the pull at once; the held state follows
  // once the synchronised copies show the block disabled.
  assign flt_pull_low = fault_q & en & arm_n;
  assign flt_line_n   = ~flt_pull_low;
endmodule

// File: rtl/ofh_fault_flag_chk.sv
module ofh_fault_flag_chk #(
  parameter int unsigned HOLD_CYCLES = 4,
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          arm_n,
  input logic          flt_pull_low,
  input logic          oc_s,
  input logic          blocked_s,
  input logic          ref_rise,
  input logic          fault_q,
  input logic [CW-1:0] hold_cnt
);
  // R2 / R3: a qualified overcurrent sets the held fault
  p_set_on_oc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_s && !blocked_s) |=> fault_q);

  // R9: a synchronised block discards the fault
  p_block_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_s |=> !fault_q);

  // R10: no release without a reference rising edge
  p_hold_no_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !blocked_s && !ref_rise) |=> fault_q);

  // R5: the clean-edge count stays within the limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt < CW'(HOLD_CYCLES));

  // R6: an overcurrent restarts the count
  p_oc_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_s |=> (hold_cnt == '0));

  // R7: enable low removes the pull at once
  p_en_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !flt_pull_low);

  // R8: arm low removes the pull at once
  p_arm_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_n |-> !flt_pull_low);
endmodule

bind ofh_fault_flag ofh_fault_flag_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .arm_n        (arm_n),
  .flt_pull_low (flt_pull_low),
  .oc_s         (oc_s),
  .blocked_s    (blocked_s),
  .ref_rise     (ref_rise),
  .fault_q      (fault_q),
  .hold_cnt     (hold_cnt)
);

// File: tb/sim_ofh_fault_flag.sv
`timescale 1ns/1ps
module sim_ofh_fault_flag;
  localparam int SYNC = 2;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_ref = 1'b0, oc_hi = 1'b0, oc_lo = 1'b0, en = 1'b0, arm_n = 1'b0;
  logic flt_pull_low, flt_line_n;

  int n_vec = 0;
  int n_bad = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  ofh_fault_flag #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_ref(sw_ref), .oc_hi(oc_hi), .oc_lo(oc_lo),
    .en(en), .arm_n(arm_n), .flt_pull_low(flt_pull_low), .flt_line_n(flt_line_n)
  );

  // Behavioural reference: queues stand for the synchroniser.
  int q_ref[$], q_oc[$], q_blk[$];
  int m_prev, m_fault, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ref = {}; q_oc = {}; q_blk = {};
      for (int i = 0; i < SYNC; i++) begin
        q_ref.push_back(0); q_oc.push_back(0); q_blk.push_back(1);
      end
      m_prev = 0; m_fault = 0; m_cnt = 0;
    end else begin
      int r, o, b;
      r = q_ref[0]; o = q_oc[0]; b = q_blk[0];
      if (b != 0) begin
        m_fault = 0; m_cnt = 0;
      end else if (o != 0) begin
        m_fault = 1; m_cnt = 0;
      end else if (m_fault != 0 && r != 0 && m_prev == 0) begin
        m_cnt++;
        if (m_cnt == HOLD) begin m_fault = 0; m_cnt = 0; end
      end
      m_prev = r;
      void'(q_ref.pop_front()); void'(q_oc.pop_front()); void'(q_blk.pop_front());
      q_ref.push_back(int'(sw_ref));
      q_oc.push_back(int'(oc_hi | oc_lo));
      q_blk.push_back(int'(!(en && arm_n)));
    end
  end

  // One clock: compare at the falling edge, before new inputs are driven.
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      logic exp_pull;
      @(negedge clk);
      exp_pull = (m_fault != 0) && en && arm_n;
      n_vec++;
      if (flt_pull_low !== exp_pull) begin
        n_bad++;
        $display("FAIL %s: flt_pull_low=%b expected %b at %0t", phase, flt_pull_low, exp_pull, $time);
      end
      n_vec++;
      if (flt_line_n !== ~exp_pull) begin
        n_bad++;
        $display("FAIL R4: flt_line_n=%b expected %b at %0t", flt_line_n, ~exp_pull, $time);
      end
    end
  endtask

  task automatic ref_cycles(int n);
    for (int i = 0; i < n; i++) begin
      sw_ref = 1'b1; step(3);
      sw_ref = 1'b0; step(3);
    end
  endtask

  task automatic pulse_hi();
    oc_hi = 1'b1; step(1); oc_hi = 1'b0; step(4);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    phase = "R1";
    step(3);
    rst_n = 1'b1; en = 1'b1; arm_n = 1'b1;
    step(6);

    phase = "R2";   // high-side trip, fault visible SYNC+1 edges later
    pulse_hi();
    phase = "R5";   // release after HOLD clean reference edges
    ref_cycles(HOLD + 1);
    step(4);

    phase = "R3";   // low-side trip
    oc_lo = 1'b1; step(2); oc_lo = 1'b0; step(4);
    phase = "R6";   // overcurrent in mid-count restarts
    ref_cycles(2);
    oc_lo = 1'b1; step(1); oc_lo = 1'b0; step(3);
    ref_cycles(HOLD - 1);
    ref_cycles(2);
    step(4);

    phase = "R10";  // reference held high: no release
    pulse_hi();
    sw_ref = 1'b1; step(60);
    sw_ref = 1'b0; step(20);

    phase = "R7";   // enable low drops the pull at once
    en = 1'b0; step(6);
    phase = "R9";   // indications while disabled are ignored
    oc_hi = 1'b1; oc_lo = 1'b1; step(4);
    oc_hi = 1'b0; oc_lo = 1'b0; step(2);
    en = 1'b1; step(10);
    ref_cycles(1);

    phase = "R8";   // functional reset input low drops the pull at once
    pulse_hi();
    arm_n = 1'b0; step(6);
    phase = "R9";
    oc_lo = 1'b1; step(3); oc_lo = 1'b0; step(2);
    arm_n = 1'b1; step(10);

    phase = "R5";   // re-trip after recovery, full hold again
    pulse_hi();
    ref_cycles(HOLD - 1);
    step(10);
    ref_cycles(2);
    step(4);

    finish_run();
  end
endmodule